// File: doc/BRIEF.md
# Ethernet Carrier Sense Detector

This block produces the carrier sense flag of a 10 Mb/s physical layer. It looks at a decoded receive bit stream and its per-bit strobe, and at a receive activity line. From these it decides when a frame really starts and when it ends. A receive frame only raises carrier once a run of alternating bits, the preamble, has been seen. Carrier drops again once the activity line has been quiet for a set number of bit strobes.

The duplex select sets what transmit activity does. In half duplex, a high transmit enable also holds carrier up. In full duplex, only the receive side counts. A digital loopback select swaps the receive source. The block then takes the encoded transmit bit stream, its strobe and the transmit enable as its bit, strobe and activity inputs, and disregards the media inputs. A separate MII loopback request overrides the digital one: when both are set, the digital path is switched off and the media inputs are used.

Top module: `eth_crs_detect`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `crs_o` is 0 and the frame tracker is idle.
- R2: With `full_duplex_i`=0, a high `tx_en_i` sampled at a clock edge makes `crs_o` 1 after that edge, whatever the receive side is doing.
- R3: With `full_duplex_i`=1, `tx_en_i` has no effect on `crs_o`, and `crs_o` is 1 only while a receive frame holds carrier.
- R4: Receive carrier is raised by the bit strobe that delivers the 8th consecutive alternating bit (PRE_BITS=8) while activity is high. `crs_o` rises one clock after the edge that samples that strobe. Fewer alternating bits leave it low.
- R5: A bit equal to its predecessor breaks the run, and the breaking bit counts as the first bit of a new run. The preamble then needs PRE_BITS-1 more alternating bits.
- R6: Once carrier is up, it is released by the 2nd consecutive bit strobe taken with activity low (EOF_BITS=2), and `crs_o` falls one clock later. A strobe with activity high between two quiet strobes restarts the quiet count.
- R7: Any clock with activity low clears the alternating run, even if no strobe arrives.
- R8: With `dig_lpbk_i`=1 and `mii_lpbk_i`=0, the receive source is `tx_ser_i`/`tx_ser_vld_i`, with `tx_en_i` as activity. Media inputs `rx_act_i`, `rx_bit_i` and `rx_bit_vld_i` are ignored.
- R9: With `dig_lpbk_i`=1 and `mii_lpbk_i`=1, the digital loopback is off. The media inputs feed the receive path and the transmit bit stream is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| dig_lpbk_i | input | 1 | Route encoded transmit stream to the receive input |
| mii_lpbk_i | input | 1 | MII loopback request; overrides digital loopback |
| tx_en_i | input | 1 | Transmit enable |
| tx_ser_i | input | 1 | Encoded transmit bit |
| tx_ser_vld_i | input | 1 | Strobe for `tx_ser_i` |
| rx_act_i | input | 1 | Media receive activity |
| rx_bit_i | input | 1 | Decoded media receive bit |
| rx_bit_vld_i | input | 1 | Strobe for `rx_bit_i` |
| crs_o | output | 1 | Registered carrier sense |

## Verification
The bench goes after the preamble edge: seven alternating bits must leave carrier low and the eighth must raise it. A counter off by one would raise carrier a bit early or late. A break at the seventh bit is tested to show that the breaking bit starts the new run; a design that restarted from zero would need one bit too many. An activity gap with no strobe is tested too; a design that cleared the run only on strobes would raise carrier early. On the end-of-frame side, the bench checks that one quiet strobe, or a quiet strobe followed by an active one, keeps carrier up, and that the second quiet strobe drops it. The bench also drives a live preamble on the wrong source in both loopback settings. A swapped or unprioritised source select would then show carrier that should not be there.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_HUNT  = 2'd1,
    FR_CARRY = 2'd2
  } frame_e;

  // Length of the alternating run after one more accepted bit.
  function automatic int run_step(int run, logic prev, logic cur, int lim);
    int nxt;
    if (run == 0)          nxt = 1;
    else if (cur != prev)  nxt = run + 1;
    else                   nxt = 1;
    if (nxt > lim) nxt = lim;
    return nxt;
  endfunction

  // Quiet-strobe count after one more strobe taken with activity low.
  function automatic int quiet_step(int cnt, int lim);
    int nxt;
    nxt = cnt + 1;
    if (nxt > lim) nxt = lim;
    return nxt;
  endfunction

endpackage

// File: rtl/ecs_src_sel.sv
module ecs_src_sel (
  input  logic dig_lpbk_i,
  input  logic mii_lpbk_i,
  input  logic tx_en_i,
  input  logic tx_ser_i,
  input  logic tx_ser_vld_i,
  input  logic rx_act_i,
  input  logic rx_bit_i,
  input  logic rx_bit_vld_i,
  output logic loop_on,
  output logic src_act,
  output logic src_bit,
  output logic src_vld
);
  // MII loopback wins over the digital loopback path.
  assign loop_on = dig_lpbk_i & ~mii_lpbk_i;

  always_comb begin
    if (loop_on) begin
      src_act = tx_en_i;
      src_bit = tx_ser_i;
      src_vld = tx_ser_vld_i;
    end else begin
      src_act = rx_act_i;
      src_bit = rx_bit_i;
      src_vld = rx_bit_vld_i;
    end
  end
endmodule

// File: rtl/ecs_preamble.sv
module ecs_preamble #(
  parameter int PRE_BITS = 8,
  localparam int RW = $clog2(PRE_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_act,
  input  logic          src_bit,
  input  logic          src_vld,
  output logic [RW-1:0] run_cnt,
  output logic          pre_hit
);
  import ecs_pkg::*;

  logic          prev_bit;
  logic [RW-1:0] run_nxt;

  assign run_nxt = RW'(run_step(int'(run_cnt), prev_bit, src_bit, PRE_BITS));
  assign pre_hit = src_vld & src_act & (int'(run_nxt) == PRE_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      prev_bit <= 1'b0;
    end else if (!src_act) begin
      run_cnt  <= '0;
    end else if (src_vld) begin
      run_cnt  <= run_nxt;
      prev_bit <= src_bit;
    end
  end
endmodule

// File: rtl/ecs_eof.sv
module ecs_eof #(
  parameter int EOF_BITS = 2,
  localparam int QW = $clog2(EOF_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_act,
  input  logic          src_vld,
  output logic [QW-1:0] quiet_cnt,
  output logic          eof_hit
);
  import ecs_pkg::*;

  logic [QW-1:0] quiet_nxt;

  assign quiet_nxt = QW'(quiet_step(int'(quiet_cnt), EOF_BITS));
  assign eof_hit   = src_vld & ~src_act & (int'(quiet_nxt) == EOF_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet_cnt <= '0;
    else if (src_act)  quiet_cnt <= '0;
    else if (src_vld)  quiet_cnt <= quiet_nxt;
  end
endmodule

// File: rtl/ecs_frame_fsm.sv
module ecs_frame_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic src_act,
  input  logic pre_hit,
  input  logic eof_hit,
  output logic rx_carry
);
  import ecs_pkg::*;

  frame_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FR_IDLE:  if (pre_hit) st_d = FR_CARRY;
                else if (src_act) st_d = FR_HUNT;
      FR_HUNT:  if (eof_hit) st_d = FR_IDLE;
                else if (pre_hit) st_d = FR_CARRY;
      FR_CARRY: if (eof_hit) st_d = FR_IDLE;
      default:  st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FR_IDLE;
    else        st_q <= st_d;
  end

  assign rx_carry = (st_q == FR_CARRY);
endmodule

// File: rtl/eth_crs_detect.sv
module eth_crs_detect #(
  parameter int PRE_BITS = 8,
  parameter int EOF_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic full_duplex_i,
  input  logic dig_lpbk_i,
  input  logic mii_lpbk_i,
  input  logic tx_en_i,
  input  logic tx_ser_i,
  input  logic tx_ser_vld_i,
  input  logic rx_act_i,
  input  logic rx_bit_i,
  input  logic rx_bit_vld_i,
  output logic crs_o
);
  localparam int RW = $clog2(PRE_BITS + 1);
  localparam int QW = $clog2(EOF_BITS + 1);

  // Named internal events, observed by the bound checker.
  logic          loop_on;
  logic          src_act, src_bit, src_vld;
  logic [RW-1:0] run_cnt;
  logic [QW-1:0] quiet_cnt;
  logic          pre_hit, eof_hit;
  logic          rx_carry;
  logic          crs_d;

  ecs_src_sel u_sel (
    .dig_lpbk_i   (dig_lpbk_i),
    .mii_lpbk_i   (mii_lpbk_i),
    .tx_en_i      (tx_en_i),
    .tx_ser_i     (tx_ser_i),
    .tx_ser_vld_i (tx_ser_vld_i),
    .rx_act_i     (rx_act_i),
    .rx_bit_i     (rx_bit_i),
    .rx_bit_vld_i (rx_bit_vld_i),
    .loop_on      (loop_on),
    .src_act      (src_act),
    .src_bit      (src_bit),
    .src_vld      (src_vld)
  );

  ecs_preamble #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_act (src_act),
    .src_bit (src_bit),
    .src_vld (src_vld),
    .run_cnt (run_cnt),
    .pre_hit (pre_hit)
  );

  ecs_eof #(.EOF_BITS(EOF_BITS)) u_eof (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_act   (src_act),
    .src_vld   (src_vld),
    .quiet_cnt (quiet_cnt),
    .eof_hit   (eof_hit)
  );

  ecs_frame_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_act  (src_act),
    .pre_hit  (pre_hit),
    .eof_hit  (eof_hit),
    .rx_carry (rx_carry)
  );

  // Half duplex lets transmit hold carrier; full duplex listens to receive only.
  assign crs_d = (~full_duplex_i & tx_en_i) | rx_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crs_o <= 1'b0;
    else        crs_o <= crs_d;
  end
endmodule

// File: rtl/ecs_checker.sv
module ecs_checker #(
  parameter int PRE_BITS = 8,
  parameter int EOF_BITS = 2,
  localparam int RW = $clog2(PRE_BITS + 1),
  localparam int QW = $clog2(EOF_BITS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          full_duplex_i,
  input logic          dig_lpbk_i,
  input logic          mii_lpbk_i,
  input logic          tx_en_i,
  input logic          crs_o,
  input logic          rx_carry,
  input logic [RW-1:0] run_cnt,
  input logic [QW-1:0] quiet_cnt
);
  assert_half_duplex_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex_i && tx_en_i) |=> crs_o);

  assert_full_duplex_rx_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex_i && !rx_carry) |=> !crs_o);

  assert_carry_after_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_carry) |-> (int'($past(run_cnt)) == PRE_BITS - 1));

  assert_release_on_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_carry) |-> (int'($past(quiet_cnt)) == EOF_BITS - 1));

  assert_loop_ignores_media_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_lpbk_i && !mii_lpbk_i && !tx_en_i && !rx_carry) |=> !rx_carry);
endmodule

bind eth_crs_detect ecs_checker #(.PRE_BITS(PRE_BITS), .EOF_BITS(EOF_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .full_duplex_i (full_duplex_i),
  .dig_lpbk_i    (dig_lpbk_i),
  .mii_lpbk_i    (mii_lpbk_i),
  .tx_en_i       (tx_en_i),
  .crs_o         (crs_o),
  .rx_carry      (rx_carry),
  .run_cnt       (run_cnt),
  .quiet_cnt     (quiet_cnt)
);

// File: tb/eth_crs_detect_tb.sv
module eth_crs_detect_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, full_duplex_i, dig_lpbk_i, mii_lpbk_i;
  logic tx_en_i, tx_ser_i, tx_ser_vld_i;
  logic rx_act_i, rx_bit_i, rx_bit_vld_i;
  logic crs_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  eth_crs_detect u_dut (
    .clk(clk), .rst_n(rst_n), .full_duplex_i(full_duplex_i),
    .dig_lpbk_i(dig_lpbk_i), .mii_lpbk_i(mii_lpbk_i),
    .tx_en_i(tx_en_i), .tx_ser_i(tx_ser_i), .tx_ser_vld_i(tx_ser_vld_i),
    .rx_act_i(rx_act_i), .rx_bit_i(rx_bit_i), .rx_bit_vld_i(rx_bit_vld_i),
    .crs_o(crs_o)
  );

  // Monitor: just after each falling edge, compare every queued expectation.
  always begin
    @(negedge clk);
    #1;
    while (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (crs_o !== e) begin
        fails++;
        $display("FAIL %s: crs_o=%b expected=%b", t, crs_o, e);
      end
    end
  end

  task automatic expect_now(input bit e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // One bit strobe on media (lp=0) or transmit stream (lp=1); expectation
  // is queued one clock after the edge that takes the strobe.
  task automatic send(input bit lp, input bit act, input bit b, input bit e, input string t);
    if (lp) begin tx_en_i = act; tx_ser_i = b; tx_ser_vld_i = 1'b1; end
    else    begin rx_act_i = act; rx_bit_i = b; rx_bit_vld_i = 1'b1; end
    @(negedge clk);
    tx_ser_vld_i = 1'b0;
    rx_bit_vld_i = 1'b0;
    @(negedge clk);
    expect_now(e, t);
  endtask

  task automatic alt_run(input bit lp, input bit first, input int n, input bit last_e, input string t);
    for (int i = 0; i < n; i++)
      send(lp, 1'b1, first ^ i[0], (i == n - 1) ? last_e : 1'b0, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; full_duplex_i = 1'b0; dig_lpbk_i = 1'b0; mii_lpbk_i = 1'b0;
    tx_en_i = 1'b0; tx_ser_i = 1'b0; tx_ser_vld_i = 1'b0;
    rx_act_i = 1'b0; rx_bit_i = 1'b0; rx_bit_vld_i = 1'b0;
    repeat (3) @(negedge clk);
    expect_now(1'b0, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(1'b0, "R1 after reset");

    // R2: half duplex transmit raises carrier
    tx_en_i = 1'b1;
    @(negedge clk); expect_now(1'b1, "R2 tx in half duplex");
    tx_en_i = 1'b0;
    @(negedge clk); expect_now(1'b0, "R2 tx released");

    // R3: full duplex ignores transmit
    full_duplex_i = 1'b1; tx_en_i = 1'b1;
    @(negedge clk); expect_now(1'b0, "R3 tx ignored");
    @(negedge clk); expect_now(1'b0, "R3 tx ignored hold");
    tx_en_i = 1'b0;

    // R4: eighth alternating bit raises carrier
    alt_run(1'b0, 1'b1, 8, 1'b1, "R4 preamble");
    send(1'b0, 1'b1, 1'b1, 1'b1, "R4 data keeps carrier");
    send(1'b0, 1'b1, 1'b1, 1'b1, "R4 data keeps carrier");

    // R6: quiet count, restart on activity, release on second quiet strobe
    send(1'b0, 1'b0, 1'b0, 1'b1, "R6 one quiet strobe");
    send(1'b0, 1'b1, 1'b0, 1'b1, "R6 activity resumes");
    send(1'b0, 1'b0, 1'b0, 1'b1, "R6 quiet restarted");
    send(1'b0, 1'b0, 1'b0, 1'b0, "R6 end of frame");

    // R5: break at seventh bit starts a new run of one
    alt_run(1'b0, 1'b0, 6, 1'b0, "R5 partial run");
    send(1'b0, 1'b1, 1'b1, 1'b0, "R5 breaking bit");
    alt_run(1'b0, 1'b0, 7, 1'b1, "R5 run after break");
    send(1'b0, 1'b0, 1'b0, 1'b1, "R6 quiet one");
    send(1'b0, 1'b0, 1'b0, 1'b0, "R6 quiet two");

    // R7: an activity gap without a strobe clears the run
    alt_run(1'b0, 1'b1, 7, 1'b0, "R7 seven bits");
    rx_act_i = 1'b0;
    @(negedge clk); expect_now(1'b0, "R7 gap");
    rx_act_i = 1'b1;
    alt_run(1'b0, 1'b0, 7, 1'b0, "R7 restarted run");
    send(1'b0, 1'b1, 1'b1, 1'b1, "R7 eighth after gap");
    send(1'b0, 1'b0, 1'b0, 1'b1, "R6 quiet one");
    send(1'b0, 1'b0, 1'b0, 1'b0, "R6 quiet two");

    // R8: digital loopback ignores media, uses transmit stream
    dig_lpbk_i = 1'b1;
    alt_run(1'b0, 1'b1, 8, 1'b0, "R8 media ignored");
    rx_act_i = 1'b0;
    alt_run(1'b1, 1'b1, 8, 1'b1, "R8 looped preamble");
    send(1'b1, 1'b0, 1'b0, 1'b1, "R8 looped quiet one");
    send(1'b1, 1'b0, 1'b0, 1'b0, "R8 looped end");

    // R9: MII loopback request disables the digital path
    mii_lpbk_i = 1'b1;
    alt_run(1'b1, 1'b1, 8, 1'b0, "R9 tx stream ignored");
    tx_en_i = 1'b0;
    alt_run(1'b0, 1'b1, 8, 1'b1, "R9 media preamble");
    send(1'b0, 1'b0, 1'b0, 1'b1, "R9 quiet one");
    send(1'b0, 1'b0, 1'b0, 1'b0, "R9 end");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule